// File: doc/BRIEF.md
# Compressed Instruction Decoder

This block turns a 16-bit compressed RISC-V instruction into the micro-operation record that a simple core's execute stage uses. The record holds the operation class, the ALU function, the destination and source register indices, a fully extended immediate, the memory access size, a link flag, a word-result flag and an illegal flag. The result is registered, so the record for an instruction sampled on one rising clock edge is valid after that edge and stays until the next one.

The XLEN parameter (32 or 64) decides which encodings are legal and how the one shared opcode slot is read. The `ext_en_i` input comes from the compressed-extension bit of the machine ISA register. When it is low, every halfword decodes as illegal. Floating-point compressed forms are not supported. Execution, the register file and memory are outside this block.

Top module: `rvc_decoder`

## Requirements
- R1: When `ext_en_i` is 0, or when bits [1:0] of the instruction are 2'b11, the record is illegal.
- R2: A 3-bit compact register field f selects register 8+f. This applies to the compact rd, rs1 and rs2 fields: rd/rs2' at bits [4:2] and rs1' at bits [9:7].
- R3: Quadrant 01 with funct3 001 decodes as a jump-and-link when XLEN=32. When XLEN=64 it decodes as an add-word-immediate with rd=rs1=bits [11:7] and `word_o`=1. When XLEN=64 and rd is 0, it is illegal.
- R4: The jump-and-link and jump-and-link-register forms set `link_o`=1 and `rd_o`=1, so the return address (pc+2) goes to x1. The plain jump and jump-register forms set `link_o`=0 and `rd_o`=0.
- R5: Quadrant 10 with funct3 100 is split by bit 12 and by the rs2 field (bits [6:2]) and rd field (bits [11:7]):
  - bit 12 = 0, rs2 != 0: move (class 0, rs1=0).
  - bit 12 = 0, rs2 = 0: jump-register (class 6). It is illegal when rd is 0.
  - bit 12 = 1, rs2 != 0: add (class 0, rs1=rd).
  - bit 12 = 1, rs2 = 0, rd != 0: jump-and-link-register.
  - bit 12 = 1, rs2 = 0, rd = 0: breakpoint (class 7).
- R6: When XLEN=32, these forms are illegal: add-word, subtract-word, load-double, store-double, SP-relative load-double and SP-relative store-double.
- R7: A shift-immediate with a shift amount of 0 is illegal. When XLEN=32, a shift amount above 31 is illegal.
- R8: Branch-if-zero (funct3 110) and branch-if-not-zero (funct3 111) in quadrant 01 give:
  - class 4 and function 8 (equal) or 9 (not equal);
  - rs1 = compact rs1, rs2 = 0 and rd = 0;
  - the sign-extended, scrambled 9-bit pc offset.
- R9: `size_o` is log2 of the access byte count, and 0 when there is no memory access. Word loads and stores use size 2, and the word loads also set `word_o`. Double forms use size 3.
- R10: These halfwords are illegal:
  - the all-zero halfword and any add-to-SP-times-4 form with a zero immediate;
  - an SP adjust or upper-immediate load with a zero immediate;
  - the floating-point and reserved slots.
  
  An illegal record has every other field 0.
- R11: Immediates are rebuilt from the standard compressed bit scrambles and extended to XLEN bits. The upper-immediate load places its 6-bit field at bits 17:12, sign-extended.
- R12: The record is registered with one cycle of latency. While `rst_ni` is low, all outputs are 0.

Class codes: 0 register ALU, 1 immediate ALU, 2 load, 3 store, 4 branch, 5 jump, 6 jump-register, 7 breakpoint.

Function codes: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 sll, 6 srl, 7 sra, 8 eq, 9 ne.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 16 | Compressed instruction halfword |
| ext_en_i | input | 1 | Compressed extension enabled |
| op_class_o | output | 3 | Operation class code |
| alu_fn_o | output | 4 | ALU function code |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| imm_o | output | XLEN | Extended immediate |
| size_o | output | 2 | log2 of access bytes, 0 if none |
| link_o | output | 1 | Write return address to x1 |
| word_o | output | 1 | Result is sign-extended from 32 bits |
| illegal_o | output | 1 | Instruction is illegal |

## Verification
Each of the three quadrants is driven with its arithmetic, logical, shift, memory, branch and jump forms. Immediates are chosen with the sign bit set so that a wrong scramble or a wrong extension changes the value. Some encodings are applied to both an XLEN=32 and an XLEN=64 instance: the shared jump-and-link / add-word-immediate slot and the double-word and word-arithmetic forms. This separates a decode that ignores XLEN from one that uses it. Zero immediates, a zero shift amount, a shift amount above 31 and a disabled extension show whether the reserved encodings are caught. Mid-run reset and back-to-back vectors check the register stage.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

  typedef enum logic [2:0] {
    CLS_ALU_REG = 3'd0,
    CLS_ALU_IMM = 3'd1,
    CLS_LOAD    = 3'd2,
    CLS_STORE   = 3'd3,
    CLS_BRANCH  = 3'd4,
    CLS_JUMP    = 3'd5,
    CLS_JREG    = 3'd6,
    CLS_BREAK   = 3'd7
  } op_class_e;

  typedef enum logic [3:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_AND = 4'd2,
    FN_OR  = 4'd3,
    FN_XOR = 4'd4,
    FN_SLL = 4'd5,
    FN_SRL = 4'd6,
    FN_SRA = 4'd7,
    FN_EQ  = 4'd8,
    FN_NE  = 4'd9
  } alu_fn_e;

  typedef enum logic [3:0] {
    IMM_NONE,
    IMM_CI,
    IMM_SH,
    IMM_LUI,
    IMM_SP16,
    IMM_SPN4,
    IMM_CLW,
    IMM_CLD,
    IMM_CJ,
    IMM_CB,
    IMM_LWSP,
    IMM_LDSP,
    IMM_SWSP,
    IMM_SDSP
  } imm_sel_e;

  localparam logic [1:0] SZ_NONE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  typedef struct packed {
    op_class_e  cls;
    alu_fn_e    fn;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
    imm_sel_e   imm_sel;
    logic [1:0] size;
    logic       link;
    logic       word;
    logic       ill;
  } uop_t;

  function automatic logic [4:0] creg(input logic [2:0] f);
    return {2'b01, f};
  endfunction

endpackage

// File: rtl/rvc_imm_gen.sv
module rvc_imm_gen
  import rvc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [12:2]     bits_i,
  input  imm_sel_e        sel_i,
  output logic [XLEN-1:0] imm_o
);
  localparam int RAW_W = 32;

  logic [12:0]      i;
  logic [RAW_W-1:0] v;

  assign i = {bits_i, 2'b00};

  always_comb begin
    unique case (sel_i)
      IMM_CI:   v = {{26{i[12]}}, i[12], i[6:2]};
      IMM_SH:   v = {26'b0, i[12], i[6:2]};
      IMM_LUI:  v = {{14{i[12]}}, i[12], i[6:2], 12'b0};
      IMM_SP16: v = {{22{i[12]}}, i[12], i[4:3], i[5], i[2], i[6], 4'b0};
      IMM_SPN4: v = {22'b0, i[10:7], i[12:11], i[5], i[6], 2'b0};
      IMM_CLW:  v = {25'b0, i[5], i[12:10], i[6], 2'b0};
      IMM_CLD:  v = {24'b0, i[6:5], i[12:10], 3'b0};
      IMM_CJ:   v = {{20{i[12]}}, i[12], i[8], i[10:9], i[6], i[7], i[2], i[11], i[5:3], 1'b0};
      IMM_CB:   v = {{23{i[12]}}, i[12], i[6:5], i[2], i[11:10], i[4:3], 1'b0};
      IMM_LWSP: v = {24'b0, i[3:2], i[12], i[6:4], 2'b0};
      IMM_LDSP: v = {23'b0, i[4:2], i[12], i[6:5], 3'b0};
      IMM_SWSP: v = {24'b0, i[8:7], i[12:9], 2'b0};
      IMM_SDSP: v = {23'b0, i[9:7], i[12:10], 3'b0};
      default:  v = '0;
    endcase
  end

  // all zero-extended forms have bit 31 clear, so one signed widening serves all
  assign imm_o = XLEN'($signed(v));

endmodule

// File: rtl/rvc_decode_core.sv
module rvc_decode_core
  import rvc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [15:0] instr_i,
  input  logic        ext_en_i,
  output uop_t        uop_o
);
  localparam bit IS64 = (XLEN == 64);

  logic [2:0] f3;
  logic [4:0] rdf, rs2f, rdp, rs1p;
  logic       imm6_zero, sh_bad, bad;
  uop_t       u;

  assign f3        = instr_i[15:13];
  assign rdf       = instr_i[11:7];
  assign rs2f      = instr_i[6:2];
  assign rdp       = creg(instr_i[4:2]);
  assign rs1p      = creg(instr_i[9:7]);
  assign imm6_zero = ({instr_i[12], instr_i[6:2]} == 6'd0);
  assign sh_bad    = imm6_zero || (!IS64 && instr_i[12]);

  always_comb begin
    u   = '0;
    bad = 1'b0;
    unique case (instr_i[1:0])
      2'b00: begin
        unique case (f3)
          3'b000: begin
            u.cls = CLS_ALU_IMM; u.rd = rdp; u.rs1 = 5'd2; u.imm_sel = IMM_SPN4;
            bad = (instr_i[12:5] == 8'd0);
          end
          3'b010: begin
            u.cls = CLS_LOAD; u.rd = rdp; u.rs1 = rs1p; u.imm_sel = IMM_CLW;
            u.size = SZ_WORD; u.word = 1'b1;
          end
          3'b011: begin
            u.cls = CLS_LOAD; u.rd = rdp; u.rs1 = rs1p; u.imm_sel = IMM_CLD;
            u.size = SZ_DWORD; bad = !IS64;
          end
          3'b110: begin
            u.cls = CLS_STORE; u.rs1 = rs1p; u.rs2 = rdp; u.imm_sel = IMM_CLW;
            u.size = SZ_WORD;
          end
          3'b111: begin
            u.cls = CLS_STORE; u.rs1 = rs1p; u.rs2 = rdp; u.imm_sel = IMM_CLD;
            u.size = SZ_DWORD; bad = !IS64;
          end
          default: bad = 1'b1;
        endcase
      end
      2'b01: begin
        unique case (f3)
          3'b000: begin
            u.cls = CLS_ALU_IMM; u.rd = rdf; u.rs1 = rdf; u.imm_sel = IMM_CI;
          end
          3'b001: begin
            if (IS64) begin
              u.cls = CLS_ALU_IMM; u.rd = rdf; u.rs1 = rdf; u.imm_sel = IMM_CI;
              u.word = 1'b1; bad = (rdf == 5'd0);
            end else begin
              u.cls = CLS_JUMP; u.rd = 5'd1; u.link = 1'b1; u.imm_sel = IMM_CJ;
            end
          end
          3'b010: begin
            u.cls = CLS_ALU_IMM; u.rd = rdf; u.imm_sel = IMM_CI;
          end
          3'b011: begin
            u.cls = CLS_ALU_IMM; bad = imm6_zero;
            if (rdf == 5'd2) begin
              u.rd = 5'd2; u.rs1 = 5'd2; u.imm_sel = IMM_SP16;
            end else begin
              u.rd = rdf; u.imm_sel = IMM_LUI;
            end
          end
          3'b100: begin
            u.rd = rs1p; u.rs1 = rs1p;
            unique case (instr_i[11:10])
              2'b00, 2'b01: begin
                u.cls = CLS_ALU_IMM; u.imm_sel = IMM_SH; bad = sh_bad;
                u.fn  = instr_i[10] ? FN_SRA : FN_SRL;
              end
              2'b10: begin
                u.cls = CLS_ALU_IMM; u.fn = FN_AND; u.imm_sel = IMM_CI;
              end
              default: begin
                u.cls = CLS_ALU_REG; u.rs2 = rdp;
                if (!instr_i[12]) begin
                  unique case (instr_i[6:5])
                    2'b00:   u.fn = FN_SUB;
                    2'b01:   u.fn = FN_XOR;
                    2'b10:   u.fn = FN_OR;
                    default: u.fn = FN_AND;
                  endcase
                end else begin
                  u.fn   = instr_i[5] ? FN_ADD : FN_SUB;
                  u.word = 1'b1;
                  bad    = !IS64 || instr_i[6];
                end
              end
            endcase
          end
          3'b101: begin
            u.cls = CLS_JUMP; u.imm_sel = IMM_CJ;
          end
          default: begin
            u.cls = CLS_BRANCH; u.rs1 = rs1p; u.imm_sel = IMM_CB;
            u.fn  = f3[0] ? FN_NE : FN_EQ;
          end
        endcase
      end
      2'b10: begin
        unique case (f3)
          3'b000: begin
            u.cls = CLS_ALU_IMM; u.fn = FN_SLL; u.rd = rdf; u.rs1 = rdf;
            u.imm_sel = IMM_SH; bad = sh_bad;
          end
          3'b010: begin
            u.cls = CLS_LOAD; u.rd = rdf; u.rs1 = 5'd2; u.imm_sel = IMM_LWSP;
            u.size = SZ_WORD; u.word = 1'b1; bad = (rdf == 5'd0);
          end
          3'b011: begin
            u.cls = CLS_LOAD; u.rd = rdf; u.rs1 = 5'd2; u.imm_sel = IMM_LDSP;
            u.size = SZ_DWORD; bad = !IS64 || (rdf == 5'd0);
          end
          3'b100: begin
            if (rs2f != 5'd0) begin
              u.cls = CLS_ALU_REG; u.rd = rdf; u.rs2 = rs2f;
              u.rs1 = instr_i[12] ? rdf : 5'd0;
            end else if (!instr_i[12]) begin
              u.cls = CLS_JREG; u.rs1 = rdf; bad = (rdf == 5'd0);
            end else if (rdf == 5'd0) begin
              u.cls = CLS_BREAK;
            end else begin
              u.cls = CLS_JREG; u.rs1 = rdf; u.rd = 5'd1; u.link = 1'b1;
            end
          end
          3'b110: begin
            u.cls = CLS_STORE; u.rs1 = 5'd2; u.rs2 = rs2f; u.imm_sel = IMM_SWSP;
            u.size = SZ_WORD;
          end
          3'b111: begin
            u.cls = CLS_STORE; u.rs1 = 5'd2; u.rs2 = rs2f; u.imm_sel = IMM_SDSP;
            u.size = SZ_DWORD; bad = !IS64;
          end
          default: bad = 1'b1;
        endcase
      end
      default: bad = 1'b1;
    endcase
    if (!ext_en_i || bad) begin
      u     = '0;
      u.ill = 1'b1;
    end
  end

  assign uop_o = u;

endmodule

// File: rtl/rvc_decoder.sv
module rvc_decoder
  import rvc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [15:0]     instr_i,
  input  logic            ext_en_i,
  output logic [2:0]      op_class_o,
  output logic [3:0]      alu_fn_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic [XLEN-1:0] imm_o,
  output logic [1:0]      size_o,
  output logic            link_o,
  output logic            word_o,
  output logic            illegal_o
);
  uop_t            uop;
  logic [XLEN-1:0] imm;

  rvc_decode_core #(.XLEN(XLEN)) u_core (
    .instr_i  (instr_i),
    .ext_en_i (ext_en_i),
    .uop_o    (uop)
  );

  rvc_imm_gen #(.XLEN(XLEN)) u_imm (
    .bits_i (instr_i[12:2]),
    .sel_i  (uop.imm_sel),
    .imm_o  (imm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_class_o <= '0;
      alu_fn_o   <= '0;
      rd_o       <= '0;
      rs1_o      <= '0;
      rs2_o      <= '0;
      imm_o      <= '0;
      size_o     <= '0;
      link_o     <= 1'b0;
      word_o     <= 1'b0;
      illegal_o  <= 1'b0;
    end else begin
      op_class_o <= uop.cls;
      alu_fn_o   <= uop.fn;
      rd_o       <= uop.rd;
      rs1_o      <= uop.rs1;
      rs2_o      <= uop.rs2;
      imm_o      <= imm;
      size_o     <= uop.size;
      link_o     <= uop.link;
      word_o     <= uop.word;
      illegal_o  <= uop.ill;
    end
  end

endmodule

// File: rtl/rvc_decoder_chk.sv
module rvc_decoder_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [15:0]     instr_i,
  input logic            ext_en_i,
  input logic [2:0]      op_class_o,
  input logic [3:0]      alu_fn_o,
  input logic [4:0]      rd_o,
  input logic [4:0]      rs1_o,
  input logic [4:0]      rs2_o,
  input logic [XLEN-1:0] imm_o,
  input logic [1:0]      size_o,
  input logic            link_o,
  input logic            word_o,
  input logic            illegal_o
);
  localparam bit IS32 = (XLEN == 32);

  a_r1_disabled_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_en_i |=> illegal_o);

  a_r1_quad3_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[1:0] == 2'b11 |=> illegal_o);

  a_r10_illegal_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (op_class_o == 3'd0 && alu_fn_o == 4'd0 && rd_o == 5'd0 &&
                   rs1_o == 5'd0 && rs2_o == 5'd0 && imm_o == '0 &&
                   size_o == 2'd0 && !link_o && !word_o));

  a_r4_link_ra: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_o |-> rd_o == 5'd1);

  a_r6_rv32_double_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (IS32 && instr_i[1:0] != 2'b01 && instr_i[14:13] == 2'b11) |=> illegal_o);

  a_r8_branch_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_class_o == 3'd4 |-> (rs2_o == 5'd0 && rd_o == 5'd0 &&
                            (alu_fn_o == 4'd8 || alu_fn_o == 4'd9)));

  a_r9_mem_has_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_class_o == 3'd2 || op_class_o == 3'd3) |-> size_o != 2'd0);

  a_r9_size_only_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_o != 2'd0 |-> (op_class_o == 3'd2 || op_class_o == 3'd3));

  a_r2_quad0_compact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_en_i && instr_i[1:0] == 2'b00) |=>
      (illegal_o || ((rd_o == 5'd0 || rd_o[4:3] == 2'b01) && rs2_o[4:3] != 2'b10)));

  a_r7_zero_shamt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[1:0] == 2'b01 && instr_i[15:13] == 3'b100 && !instr_i[11] &&
     !instr_i[12] && instr_i[6:2] == 5'd0) |=> illegal_o);

endmodule

bind rvc_decoder rvc_decoder_chk #(.XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .instr_i    (instr_i),
  .ext_en_i   (ext_en_i),
  .op_class_o (op_class_o),
  .alu_fn_o   (alu_fn_o),
  .rd_o       (rd_o),
  .rs1_o      (rs1_o),
  .rs2_o      (rs2_o),
  .imm_o      (imm_o),
  .size_o     (size_o),
  .link_o     (link_o),
  .word_o     (word_o),
  .illegal_o  (illegal_o)
);

// File: tb/rvc_decoder_test.sv
`timescale 1ns/1ps
module rvc_decoder_test;

  typedef struct packed {
    logic [15:0] ins;
    logic        rv64;
    logic        en;
    logic [2:0]  cls;
    logic [3:0]  fn;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [63:0] imm;
    logic [1:0]  sz;
    logic        lnk;
    logic        wrd;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 36;

  localparam vec_t VECS [NV] = '{
    '{16'h157D,1'b0,1'b1,3'd1,4'd0,5'd10,5'd10,5'd0, M1,                    2'd0,1'b0,1'b0,1'b0,4'd11}, // R11 addi x10,-1
    '{16'h4595,1'b0,1'b1,3'd1,4'd0,5'd11,5'd0, 5'd0, 64'd5,                 2'd0,1'b0,1'b0,1'b0,4'd11}, // R11 li
    '{16'h7605,1'b0,1'b1,3'd1,4'd0,5'd12,5'd0, 5'd0, 64'hFFFF_FFFF_FFFE_1000,2'd0,1'b0,1'b0,1'b0,4'd11}, // R11 lui 17:12
    '{16'h7605,1'b1,1'b1,3'd1,4'd0,5'd12,5'd0, 5'd0, 64'hFFFF_FFFF_FFFE_1000,2'd0,1'b0,1'b0,1'b0,4'd11}, // R11 lui rv64
    '{16'h713D,1'b0,1'b1,3'd1,4'd0,5'd2, 5'd2, 5'd0, 64'hFFFF_FFFF_FFFF_FFE0,2'd0,1'b0,1'b0,1'b0,4'd11}, // R11 sp adjust -32
    '{16'h6101,1'b0,1'b1,3'd0,4'd0,5'd0, 5'd0, 5'd0, 64'd0,                 2'd0,1'b0,1'b0,1'b1,4'd10}, // R10 sp adjust 0
    '{16'h6001,1'b0,1'b1,3'd0,4'd0,5'd0, 5'd0, 5'd0, 64'd0,                 2'd0,1'b0,1'b0,1'b1,4'd10}, // R10 lui zero
    '{16'h0800,1'b0,1'b1,3'd1,4'd0,5'd8, 5'd2, 5'd0, 64'd16,                2'd0,1'b0,1'b0,1'b0,4'd2},  // R2 sp*4 add
    '{16'h0000,1'b0,1'b1,3'd0,4'd0,5'd0, 5'd0, 5'd0, 64'd0,                 2'd0,1'b0,1'b0,1'b1,4'd10}, // R10 zero halfword
    '{16'h2000,1'b0,1'b1,3'd0,4'd0,5'd0, 5'd0, 5'd0, 64'd0,                 2'd0,1'b0,1'b0,1'b1,4'd10}, // R10 fp slot
    '{16'h4144,1'b0,1'b1,3'd2,4'd0,5'd9, 5'd10,5'd0, 64'd4,                 2'd2,1'b0,1'b1,1'b0,4'd9},  // R9 lw
    '{16'hC60C,1'b0,1'b1,3'd3,4'd0,5'd0, 5'd12,5'd11,64'd8,                 2'd2,1'b0,1'b0,1'b0,4'd9},  // R9 sw
    '{16'h6504,1'b0,1'b1,3'd0,4'd0,5'd0, 5'd0, 5'd0, 64'd0,                 2'd0,1'b0,1'b0,1'b1,4'd6},  // R6 ld rv32
    '{16'h6504,1'b1,1'b1,3'd2,4'd0,5'd9, 5'd10,5'd0, 64'd8,                 2'd3,1'b0,1'b0,1'b0,4'd9},  // R9 ld rv64
    '{16'h8C05,1'b0,1'b1,3'd0,4'd1,5'd8, 5'd8, 5'd9, 64'd0,                 2'd0,1'b0,1'b0,1'b0,4'd2},  // R2 sub
    '{16'h8D2D,1'b0,1'b1,3'd0,4'd4,5'd10,5'd10,5'd11,64'd0,                 2'd0,1'b0,1'b0,1'b0,4'd2},  // R2 xor
    '{16'h9C25,1'b1,1'b1,3'd0,4'd0,5'd8, 5'd8, 5'd9, 64'd0,                 2'd0,1'b0,1'b1,1'b0,4'd6},  // R6 addw rv64
    '{16'h9C25,1'b0,1'b1,3'd0,4'd0,5'd0, 5'd0, 5'd0, 64'd0,                 2'd0,1'b0,1'b0,1'b1,4'd6},  // R6 addw rv32
    '{16'h9C05,1'b0,1'b1,3'd0,4'd0,5'd0, 5'd0, 5'd0, 64'd0,                 2'd0,1'b0,1'b0,1'b1,4'd6},  // R6 subw rv32
    '{16'h9879,1'b0,1'b1,3'd1,4'd2,5'd8, 5'd8, 5'd0, 64'hFFFF_FFFF_FFFF_FFFE,2'd0,1'b0,1'b0,1'b0,4'd11}, // R11 andi -2
    '{16'h9485,1'b1,1'b1,3'd1,4'd7,5'd9, 5'd9, 5'd0, 64'd33,                2'd0,1'b0,1'b0,1'b0,4'd7},  // R7 srai 33 rv64
    '{16'h9485,1'b0,1'b1,3'd0,4'd0,5'd0, 5'd0, 5'd0, 64'd0,                 2'd0,1'b0,1'b0,1'b1,4'd7},  // R7 srai 33 rv32
    '{16'h8001,1'b1,1'b1,3'd0,4'd0,5'd0, 5'd0, 5'd0, 64'd0,                 2'd0,1'b0,1'b0,1'b1,4'd7},  // R7 srli 0
    '{16'h8005,1'b0,1'b1,3'd1,4'd6,5'd8, 5'd8, 5'd0, 64'd1,                 2'd0,1'b0,1'b0,1'b0,4'd7},  // R7 srli 1
    '{16'h0512,1'b0,1'b1,3'd1,4'd5,5'd10,5'd10,5'd0, 64'd4,                 2'd0,1'b0,1'b0,1'b0,4'd7},  // R7 slli 4
    '{16'h3FF5,1'b0,1'b1,3'd5,4'd0,5'd1, 5'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFC,2'd0,1'b1,1'b0,1'b0,4'd3},  // R3 jal rv32
    '{16'h3FF5,1'b1,1'b1,3'd1,4'd0,5'd31,5'd31,5'd0, 64'hFFFF_FFFF_FFFF_FFFD,2'd0,1'b0,1'b1,1'b0,4'd3},  // R3 addiw rv64
    '{16'hA021,1'b0,1'b1,3'd5,4'd0,5'd0, 5'd0, 5'd0, 64'd8,                 2'd0,1'b0,1'b0,1'b0,4'd4},  // R4 j
    '{16'hDC7D,1'b0,1'b1,3'd4,4'd8,5'd0, 5'd8, 5'd0, 64'hFFFF_FFFF_FFFF_FFFE,2'd0,1'b0,1'b0,1'b0,4'd8},  // R8 beqz
    '{16'hE099,1'b0,1'b1,3'd4,4'd9,5'd0, 5'd9, 5'd0, 64'd6,                 2'd0,1'b0,1'b0,1'b0,4'd8},  // R8 bnez
    '{16'h829A,1'b0,1'b1,3'd0,4'd0,5'd5, 5'd0, 5'd6, 64'd0,                 2'd0,1'b0,1'b0,1'b0,4'd5},  // R5 mv
    '{16'h8082,1'b0,1'b1,3'd6,4'd0,5'd0, 5'd1, 5'd0, 64'd0,                 2'd0,1'b0,1'b0,1'b0,4'd5},  // R5 jr
    '{16'h9382,1'b0,1'b1,3'd6,4'd0,5'd1, 5'd7, 5'd0, 64'd0,                 2'd0,1'b1,1'b0,1'b0,4'd4},  // R4 jalr
    '{16'h9002,1'b0,1'b1,3'd7,4'd0,5'd0, 5'd0, 5'd0, 64'd0,                 2'd0,1'b0,1'b0,1'b0,4'd5},  // R5 break
    '{16'h9192,1'b0,1'b1,3'd0,4'd0,5'd3, 5'd3, 5'd4, 64'd0,                 2'd0,1'b0,1'b0,1'b0,4'd5},  // R5 add
    '{16'h4332,1'b0,1'b1,3'd2,4'd0,5'd6, 5'd2, 5'd0, 64'd12,                2'd2,1'b0,1'b1,1'b0,4'd9}   // R9 lwsp
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic        en = 1'b1;

  logic [2:0]  cls32, cls64;
  logic [3:0]  fn32, fn64;
  logic [4:0]  rd32, rd64, rs1_32, rs1_64, rs2_32, rs2_64;
  logic [31:0] imm32;
  logic [63:0] imm64;
  logic [1:0]  sz32, sz64;
  logic        lnk32, lnk64, wrd32, wrd64, ill32, ill64;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rvc_decoder #(.XLEN(32)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .ext_en_i(en),
    .op_class_o(cls32), .alu_fn_o(fn32), .rd_o(rd32), .rs1_o(rs1_32), .rs2_o(rs2_32),
    .imm_o(imm32), .size_o(sz32), .link_o(lnk32), .word_o(wrd32), .illegal_o(ill32)
  );

  rvc_decoder #(.XLEN(64)) uut_rv64 (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .ext_en_i(en),
    .op_class_o(cls64), .alu_fn_o(fn64), .rd_o(rd64), .rs1_o(rs1_64), .rs2_o(rs2_64),
    .imm_o(imm64), .size_o(sz64), .link_o(lnk64), .word_o(wrd64), .illegal_o(ill64)
  );

  function automatic logic [93:0] pack_out(input bit use64);
    if (use64)
      return {cls64, fn64, rd64, rs1_64, rs2_64, imm64, sz64, lnk64, wrd64, ill64};
    return {cls32, fn32, rd32, rs1_32, rs2_32, 32'd0, imm32, sz32, lnk32, wrd32, ill32};
  endfunction

  function automatic logic [93:0] pack_exp(input vec_t v);
    logic [63:0] im;
    im = v.rv64 ? v.imm : {32'd0, v.imm[31:0]};
    return {v.cls, v.fn, v.rd, v.rs1, v.rs2, im, v.sz, v.lnk, v.wrd, v.ill};
  endfunction

  task automatic check(input string tag, input logic [93:0] act, input logic [93:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R12: reset state, both widths
    #1;
    check("R12 reset rv32", pack_out(1'b0), '0);
    check("R12 reset rv64", pack_out(1'b1), '0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // table walk: drive on falling edge, result is registered on the next rising edge
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      instr = VECS[k].ins;
      en    = VECS[k].en;
      @(negedge clk);
      check($sformatf("R%0d vec %0d ins %h", VECS[k].req, k, VECS[k].ins),
            pack_out(VECS[k].rv64), pack_exp(VECS[k]));
    end

    // R1: disabled extension on a legal add-immediate, both widths
    @(negedge clk); instr = 16'h157D; en = 1'b0;
    @(negedge clk);
    check("R1 disabled rv32", pack_out(1'b0), 94'd1);
    check("R1 disabled rv64", pack_out(1'b1), 94'd1);

    // R1: full-width encoding
    en = 1'b1; instr = 16'h0013;
    @(negedge clk);
    check("R1 quadrant3", pack_out(1'b0), 94'd1);

    // R6: SP-relative store-double, rv32 illegal and rv64 legal
    instr = 16'hE81E;
    @(negedge clk);
    check("R6 sdsp rv32", pack_out(1'b0), 94'd1);
    check("R9 sdsp rv64", pack_out(1'b1),
          {3'd3, 4'd0, 5'd0, 5'd2, 5'd7, 64'd16, 2'd3, 1'b0, 1'b0, 1'b0});

    // R12: one-cycle latency: output holds previous record until the edge
    instr = 16'h4595;
    #1;
    check("R12 latency hold", pack_out(1'b0), 94'd1);
    @(negedge clk);
    check("R12 latency update", pack_out(1'b0),
          {3'd1, 4'd0, 5'd11, 5'd0, 5'd0, 64'd5, 2'd0, 1'b0, 1'b0, 1'b0});

    // R12: asynchronous reset clears the record mid-run
    rst_ni = 1'b0;
    #1;
    check("R12 async reset", pack_out(1'b0), '0);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule